// File: doc/BRIEF.md
# SMRAM Control Register and Access Router

This block holds the control byte for a system-management memory window and decides, for every access into that window, whether the access is served from DRAM or forwarded to the PCI bus. Software programs the byte through a byte-wide write port. One bit in the byte is a lock. Once the lock is set, it survives every later write, and only a power-on reset clears it. While the lock is set, the "open" bit can no longer be set.

On the access side, the block reads three things: the CPU's system-management-mode indicator, an access-kind input that separates instruction fetches from data references, and the stored control byte. From these it produces a single routing decision without any clocked stage. Code fetches and data references can be routed differently. The block also raises a flag while the stored byte holds a forbidden combination, and every access made during that time goes to PCI.

Top module: `smram_router`

## Requirements
- R1: After power-on reset the control byte reads 0x02, and no access is routed to DRAM.
- R2: A write stores bits 6:3 of the written byte unchanged, clears bit 7 and forces bits 2:0 to 010. The stored bit 6 is the open bit, bit 5 the close bit, bit 4 the lock bit and bit 3 the window enable.
- R3: While the stored lock bit is 1, every write leaves the lock bit at 1 and stores the open bit as 0, whatever the written value. Only reset returns the lock bit to 0.
- R4: With the window enable at 0, code and data both go to PCI (route_dram = 0).
- R5: With the enable at 1, lock at 0 and the open/close combination legal, the routing is as follows. If open is 0 and the CPU is not in management mode, both kinds go to PCI. If close is 0 and either open is 1 or the CPU is in management mode, both go to DRAM. If close is 1, open is 0 and the CPU is in management mode, code goes to DRAM and data goes to PCI.
- R6: With the enable at 1 and lock at 1, a CPU outside management mode sends both kinds to PCI. A CPU in management mode sends code to DRAM, and sends data to DRAM when close is 0 or to PCI when close is 1.
- R7: The illegal flag is 1 exactly while the stored enable, open and close bits are all 1. While it is 1, every access goes to PCI.
- R8: route_dram follows cpu_smm and acc_code in the same cycle. A write changes the stored byte at the clock edge where wr_en is sampled high, so during the write cycle itself the routing still follows the old byte.
- R9: A write that sets the lock bit and the open bit together, while unlocked, stores both bits as 1. The lock constrains only later writes, and routing then follows the locked rules of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| cpu_smm | input | 1 | CPU is in system-management mode |
| acc_code | input | 1 | 1 = instruction fetch, 0 = data reference |
| ctrl_q | output | 8 | Stored control byte |
| route_dram | output | 1 | 1 = access served by DRAM, 0 = forwarded to PCI |
| illegal | output | 1 | Stored open and close bits are both set while enabled |

## Verification
A register write and the lock enforcement fall in the same cycle when a write arrives while the lock is already held, or when a single write sets the lock together with the open bit. The bench provokes both cases. It first writes each of the eight lock-carrying values into an unlocked register and then follows each with all sixteen second writes. For every step, the stored byte is compared with an arithmetic model of the write rule. All four combinations of management mode and access kind are then compared with an expected route, which the bench takes row by row from the routing table. Routing is also sampled inside a write cycle, where it must still reflect the old byte.

// File: rtl/smram_pkg.sv
package smram_pkg;

    localparam int CTRL_W     = 8;
    localparam int BASE_W     = 3;
    localparam int FIELD_W    = 4;
    localparam logic [BASE_W-1:0] BASE_FIXED = 3'b010;

    typedef struct packed {
        logic              rsvd;
        logic              dopen;
        logic              dcls;
        logic              dlck;
        logic              en;
        logic [BASE_W-1:0] base;
    } ctrl_t;

    typedef enum logic {
        ROUTE_PCI  = 1'b0,
        ROUTE_DRAM = 1'b1
    } route_e;

    typedef struct packed {
        route_e code;
        route_e data;
    } route_pair_t;

    function automatic ctrl_t ctrl_reset_val();
        ctrl_t c;
        c      = '0;
        c.base = BASE_FIXED;
        return c;
    endfunction

    // Next stored value for a write; the lock in the current value governs.
    function automatic ctrl_t ctrl_apply_write(ctrl_t cur, logic [CTRL_W-1:0] d);
        ctrl_t n;
        n       = ctrl_t'(d);
        n.rsvd  = 1'b0;
        n.base  = BASE_FIXED;
        if (cur.dlck) begin
            n.dlck  = 1'b1;
            n.dopen = 1'b0;
        end
        return n;
    endfunction

    function automatic logic ctrl_illegal(ctrl_t c);
        return c.en & c.dopen & c.dcls;
    endfunction

endpackage

// File: rtl/smram_ctrl_reg.sv
module smram_ctrl_reg
    import smram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_r;
    ctrl_t ctrl_nxt;

    always_comb begin
        ctrl_nxt = ctrl_r;
        if (wr_en) begin
            ctrl_nxt = ctrl_apply_write(ctrl_r, wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_r <= ctrl_reset_val();
        end else begin
            ctrl_r <= ctrl_nxt;
        end
    end

    assign ctrl = ctrl_r;

endmodule

// File: rtl/smram_route_dec.sv
module smram_route_dec
    import smram_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  cpu_smm,
    input  logic  acc_code,
    output route_e route,
    output logic  illegal
);

    logic        bad_cfg;
    logic        visible;
    route_pair_t pair;

    assign bad_cfg = ctrl_illegal(ctrl);

    // The window is reachable from management mode, or from outside it
    // only while the open bit is set on an unlocked register.
    assign visible = cpu_smm | (ctrl.dopen & ~ctrl.dlck);

    always_comb begin
        pair.code = ROUTE_PCI;
        pair.data = ROUTE_PCI;
        if (ctrl.en && !bad_cfg && visible) begin
            pair.code = ROUTE_DRAM;
            pair.data = ctrl.dcls ? ROUTE_PCI : ROUTE_DRAM;
        end
    end

    assign route   = acc_code ? pair.code : pair.data;
    assign illegal = bad_cfg;

endmodule

// File: rtl/smram_router.sv
module smram_router
    import smram_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              cpu_smm,
    input  logic              acc_code,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              route_dram,
    output logic              illegal
);

    ctrl_t  ctrl;
    route_e route;

    smram_ctrl_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl)
    );

    smram_route_dec u_dec (
        .ctrl     (ctrl),
        .cpu_smm  (cpu_smm),
        .acc_code (acc_code),
        .route    (route),
        .illegal  (illegal)
    );

    assign ctrl_q     = CTRL_W'(ctrl);
    assign route_dram = (route == ROUTE_DRAM);

endmodule

// File: rtl/smram_router_checker.sv
module smram_router_checker (
    input logic       clk,
    input logic       rst,
    input logic       wr_en,
    input logic       cpu_smm,
    input logic [7:0] ctrl_q,
    input logic       route_dram,
    input logic       illegal
);

    p_fixed_bits_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[7] == 1'b0) && (ctrl_q[2:0] == 3'b010));

    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q[4] |=> ctrl_q[4]);

    p_lock_closes_open_r3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[4] && wr_en) |=> !ctrl_q[6]);

    p_disabled_pci_r4: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q[3] |-> !route_dram);

    p_locked_outside_pci_r6: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q[4] && !cpu_smm) |-> !route_dram);

    p_illegal_pci_r7: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !route_dram);

    p_hold_without_write_r8: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(ctrl_q));

endmodule

bind smram_router smram_router_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .cpu_smm    (cpu_smm),
    .ctrl_q     (ctrl_q),
    .route_dram (route_dram),
    .illegal    (illegal)
);

// File: tb/smram_router_tb.sv
module smram_router_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       cpu_smm = 1'b0;
    logic       acc_code = 1'b0;
    logic [7:0] ctrl_q;
    logic       route_dram;
    logic       illegal;

    int checks = 0;
    int errors = 0;
    logic [7:0] model = 8'h02;

    always #4 clk = ~clk;

    smram_router u_dut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .cpu_smm    (cpu_smm),
        .acc_code   (acc_code),
        .ctrl_q     (ctrl_q),
        .route_dram (route_dram),
        .illegal    (illegal)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected route, taken row by row from the routing table.
    function automatic logic exp_dram(logic [7:0] r, logic s, logic code);
        logic o, c, l, e;
        o = r[6]; c = r[5]; l = r[4]; e = r[3];
        if (!e)     return 1'b0;
        if (o && c) return 1'b0;
        if (!l) begin
            if (!o && !s) return 1'b0;
            if (!c)       return 1'b1;
            return code;
        end
        if (!s) return 1'b0;
        return code | ~c;
    endfunction

    function automatic logic [7:0] next_model(logic [7:0] cur, logic [7:0] d);
        logic [7:0] n;
        n = {1'b0, d[6:3], 3'b010};
        if (cur[4]) begin
            n[6] = 1'b0;
            n[4] = 1'b1;
        end
        return n;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        model = 8'h02;
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
        model = next_model(model, d);
    endtask

    task automatic sweep_routes(input string req);
        for (int k = 0; k < 4; k++) begin
            cpu_smm  = k[1];
            acc_code = k[0];
            #1;
            check(req, {31'd0, route_dram}, {31'd0, exp_dram(model, k[1], k[0])});
            check("R7", {31'd0, illegal}, {31'd0, model[3] & model[6] & model[5]});
        end
    endtask

    initial begin
        #200000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset value and no DRAM routing
        check("R1", {24'd0, ctrl_q}, 32'h02);
        sweep_routes("R1");

        // Unlocked: every first write value (R2, R4, R5, R7)
        for (int v = 0; v < 16; v++) begin
            do_reset();
            do_write({v[0], v[3:0], 3'b101});
            check("R2", {24'd0, ctrl_q}, {24'd0, 1'b0, v[3:0], 3'b010});
            sweep_routes(v[0] ? "R5" : "R4");
        end

        // Lock set in the first write, then every second write (R3, R6, R9)
        for (int f = 0; f < 16; f++) begin
            if (f[1]) begin
                for (int w = 0; w < 16; w++) begin
                    do_reset();
                    do_write({1'b1, f[3:0], 3'b000});
                    check("R9", {24'd0, ctrl_q}, {24'd0, 1'b0, f[3:0], 3'b010});
                    sweep_routes("R6");
                    do_write({1'b0, w[3:0], 3'b111});
                    check("R3", {24'd0, ctrl_q}, {24'd0, model});
                    sweep_routes("R6");
                end
            end
        end

        // R3: only reset clears the lock
        do_reset();
        do_write(8'h10);
        do_write(8'h48);
        check("R3", {31'd0, ctrl_q[4]}, 32'd1);
        do_reset();
        check("R3", {24'd0, ctrl_q}, 32'h02);

        // R8: routing inside a write cycle follows the old byte
        do_reset();
        do_write(8'h08);
        cpu_smm = 1'b1; acc_code = 1'b0;
        @(negedge clk); wr_en = 1'b1; wr_data = 8'h00;
        #1;
        check("R8", {31'd0, route_dram}, 32'd1);
        @(negedge clk); wr_en = 1'b0;
        model = next_model(model, 8'h00);
        #1;
        check("R8", {31'd0, route_dram}, 32'd0);
        cpu_smm = 1'b0;
        do_write(8'h48);
        #1;
        check("R8", {31'd0, route_dram}, 32'd1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule